// File: doc/BRIEF.md
# Retention Request Sequencer

This block is the external power-side controller for one processor channel. It watches whether the processor is waiting for an interrupt and whether it reports activity. When the processor has stayed quiet long enough, the block drives an active-low quiescence request. The processor answers that request through an active-low acknowledge or an active-high deny.

Once the processor has acknowledged and an entry settle count has passed, the block raises a retention-voltage enable. A HIGH activity hint during retention drops the enable at once. After a programmable exit settle time the block lifts the request so the processor clocks can restart.

If the processor denies the request, the request is lifted immediately. The block then waits for the handshake wires to return to idle and runs a back-off count before it tries again. The acknowledge and deny wires are asynchronous and pass through a flop synchroniser before use. The configuration counts are static inputs that change only while no attempt is in progress.

Top module: `rtn_req_channel`

## Requirements
- R1: During and straight after reset, `req_n` is 1 and `vret_en` is 0.
- R2: With `core_wfi`=1, `core_active`=0, `ack_n_in`=1 and `deny_in`=0 all held, `req_n` falls on the `cfg_idle_cycles`+1-th clock edge after those levels are applied. It never falls while acknowledge is low or deny is high after synchronisation.
- R3: While `core_wfi`=0 (low-power wait for event, or running) or `core_active`=1, `req_n` stays 1 however long that lasts.
- R4: After `ack_n_in` falls with the request low, `vret_en` rises on the `cfg_entry_settle`+4-th clock edge (two synchroniser stages, one state step, then the settle count). `req_n` stays 0 throughout.
- R5: With `vret_en`=1, a 1 on `core_active` clears `vret_en` at the next clock edge. `req_n` rises on the `cfg_exit_settle`+2-th clock edge after the hint is applied.
- R6: A 1 on `deny_in` while the request is pending raises `req_n` on the third clock edge.
- R7: After a deny, once `deny_in` returns to 0 with the retention conditions still met, `req_n` falls again on the `cfg_backoff`+`cfg_idle_cycles`+5-th clock edge.
- R8: If `core_active` is 1 when the acknowledge arrives (entry settle not yet done), `vret_en` is never raised. `req_n` rises on the fourth clock edge after `ack_n_in` falls.
- R9: `req_n` rises only after a response (synchronised acknowledge low or deny high) has been seen. `vret_en` is 1 only while `req_n` is 0.
- R10: After the request is lifted, no new request is made until the synchronised acknowledge is 1 and deny is 0 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_idle_cycles | input | CNT_W | Quiet cycles required before a request |
| cfg_entry_settle | input | CNT_W | Cycles from acknowledge to voltage enable |
| cfg_exit_settle | input | CNT_W | Cycles from voltage disable to request release |
| cfg_backoff | input | CNT_W | Wait after a denied attempt |
| core_wfi | input | 1 | Processor is in wait-for-interrupt standby |
| core_active | input | 1 | Processor activity hint |
| ack_n_in | input | 1 | Asynchronous active-low acknowledge |
| deny_in | input | 1 | Asynchronous active-high deny |
| req_n | output | 1 | Active-low quiescence request |
| vret_en | output | 1 | Retention-voltage enable |

## Verification
The protocol assertions assume the processor side keeps the four-phase rules:
- acknowledge and deny are never both asserted;
- neither is asserted while the request is high;
- each returns to idle only after the request has been lifted.

The assertions also assume `core_wfi` and `core_active` are synchronous to `clk`. The bench models the processor as a task sequence that follows those rules. It drives a response only after it has seen `req_n` low, and it clears the response only after it has seen `req_n` high again. Random values cover only the settle counts, the hold times and the choice between acknowledge and deny.

// File: rtl/rtn_pkg.sv
package rtn_pkg;

   typedef enum logic [2:0] {
      ST_RUN     = 3'd0,
      ST_REQ     = 3'd1,
      ST_ENTRY   = 3'd2,
      ST_RET     = 3'd3,
      ST_EXIT    = 3'd4,
      ST_RELEASE = 3'd5,
      ST_DENYW   = 3'd6,
      ST_BACKOFF = 3'd7
   } rtn_state_t;

   function automatic logic rtn_req_low(input rtn_state_t s);
      return (s == ST_REQ) || (s == ST_ENTRY) || (s == ST_RET) || (s == ST_EXIT);
   endfunction

endpackage

// File: rtl/rtn_sync.sv
module rtn_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);

   if (STAGES < 2) begin : g_bad_stages
      $error("rtn_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("rtn_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= RST_VAL;
            else        chain[s] <= d_async;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= RST_VAL;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/rtn_down_cnt.sv
module rtn_down_cnt #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             dec,
   output logic             done
);

   if (CNT_W < 1) begin : g_bad_w
      $error("rtn_down_cnt: CNT_W must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cnt_q <= '0;
      else if (load)               cnt_q <= load_val;
      else if (dec && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
   end

   assign done = (cnt_q == '0);

   AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(load) && $past(cnt_q) == '0) |-> cnt_q == '0); // R7

endmodule

// File: rtl/rtn_seq_fsm.sv
module rtn_seq_fsm
   import rtn_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ack_n_s,
   input  logic             deny_s,
   input  logic             core_wfi,
   input  logic             core_active,
   input  logic [CNT_W-1:0] cfg_entry_settle,
   input  logic [CNT_W-1:0] cfg_exit_settle,
   input  logic [CNT_W-1:0] cfg_backoff,
   input  logic             idle_done,
   input  logic             settle_done,
   output logic             idle_load,
   output logic             idle_dec,
   output logic             settle_load,
   output logic [CNT_W-1:0] settle_val,
   output logic             req_n,
   output logic             vret_en
);

   rtn_state_t st_q, st_nxt;
   logic       hs_idle;
   logic       quiet;

   assign hs_idle = ack_n_s && !deny_s;
   assign quiet   = core_wfi && !core_active && hs_idle;

   always_comb begin
      st_nxt      = st_q;
      idle_load   = 1'b1;
      idle_dec    = 1'b0;
      settle_load = 1'b0;
      settle_val  = '0;
      unique case (st_q)
         ST_RUN: begin
            idle_load = !quiet;
            idle_dec  = quiet;
            if (quiet && idle_done) st_nxt = ST_REQ;
         end
         ST_REQ: begin
            if (!ack_n_s) begin
               st_nxt      = ST_ENTRY;
               settle_load = 1'b1;
               settle_val  = cfg_entry_settle;
            end else if (deny_s) begin
               st_nxt = ST_DENYW;
            end
         end
         ST_ENTRY: begin
            if (core_active)      st_nxt = ST_RELEASE;
            else if (settle_done) st_nxt = ST_RET;
         end
         ST_RET: begin
            if (core_active) begin
               st_nxt      = ST_EXIT;
               settle_load = 1'b1;
               settle_val  = cfg_exit_settle;
            end
         end
         ST_EXIT: begin
            if (settle_done) st_nxt = ST_RELEASE;
         end
         ST_RELEASE: begin
            if (hs_idle) st_nxt = ST_RUN;
         end
         ST_DENYW: begin
            if (hs_idle) begin
               st_nxt      = ST_BACKOFF;
               settle_load = 1'b1;
               settle_val  = cfg_backoff;
            end
         end
         ST_BACKOFF: begin
            if (settle_done) st_nxt = ST_RUN;
         end
         default: st_nxt = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_RUN;
         req_n   <= 1'b1;
         vret_en <= 1'b0;
      end else begin
         st_q    <= st_nxt;
         req_n   <= !rtn_req_low(st_nxt);
         vret_en <= (st_nxt == ST_RET);
      end
   end

   AST_REQ_FALL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(req_n) |-> $past(hs_idle)); // R2

   AST_REQ_FALL_WFI: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(req_n) |-> $past(core_wfi) && !$past(core_active)); // R3

   AST_REQ_RISE_RESP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_n) |-> ($past(!ack_n_s) || $past(deny_s))); // R9

   AST_VRET_UNDER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      vret_en |-> !req_n); // R9

   AST_EXIT_PROMPT: assert property (@(posedge clk) disable iff (!rst_n)
      (vret_en && core_active) |=> !vret_en); // R5

   AST_DENY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_REQ && ack_n_s && deny_s) |=> req_n); // R6

   AST_NO_REREQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (req_n && !hs_idle) |=> req_n); // R10

endmodule

// File: rtl/rtn_req_channel.sv
module rtn_req_channel
   import rtn_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cfg_idle_cycles,
   input  logic [CNT_W-1:0] cfg_entry_settle,
   input  logic [CNT_W-1:0] cfg_exit_settle,
   input  logic [CNT_W-1:0] cfg_backoff,
   input  logic             core_wfi,
   input  logic             core_active,
   input  logic             ack_n_in,
   input  logic             deny_in,
   output logic             req_n,
   output logic             vret_en
);

   localparam int HS_W = 2;
   localparam logic [HS_W-1:0] HS_RST = 2'b01;

   if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt
      $error("rtn_req_channel: CNT_W out of range");
   end

   logic [HS_W-1:0] hs_s;
   logic             idle_load, idle_dec, idle_done;
   logic             settle_load, settle_done;
   logic [CNT_W-1:0] settle_val;

   rtn_sync #(.WIDTH(HS_W), .STAGES(SYNC_STAGES), .RST_VAL(HS_RST)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async ({deny_in, ack_n_in}),
      .q_sync  (hs_s)
   );

   rtn_down_cnt #(.CNT_W(CNT_W)) u_idle_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (idle_load),
      .load_val (cfg_idle_cycles),
      .dec      (idle_dec),
      .done     (idle_done)
   );

   rtn_down_cnt #(.CNT_W(CNT_W)) u_settle_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (settle_load),
      .load_val (settle_val),
      .dec      (!settle_load),
      .done     (settle_done)
   );

   rtn_seq_fsm #(.CNT_W(CNT_W)) u_fsm (
      .clk              (clk),
      .rst_n            (rst_n),
      .ack_n_s          (hs_s[0]),
      .deny_s           (hs_s[1]),
      .core_wfi         (core_wfi),
      .core_active      (core_active),
      .cfg_entry_settle (cfg_entry_settle),
      .cfg_exit_settle  (cfg_exit_settle),
      .cfg_backoff      (cfg_backoff),
      .idle_done        (idle_done),
      .settle_done      (settle_done),
      .idle_load        (idle_load),
      .idle_dec         (idle_dec),
      .settle_load      (settle_load),
      .settle_val       (settle_val),
      .req_n            (req_n),
      .vret_en          (vret_en)
   );

   AST_RESET_VALUES: assert property (@(posedge clk)
      !rst_n |=> (req_n && !vret_en)); // R1

endmodule

// File: tb/test_rtn_req_channel.sv
`timescale 1ns/100ps
module test_rtn_req_channel;

   localparam int CW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [CW-1:0] cfg_idle = '0, cfg_entry = '0, cfg_exit = '0, cfg_back = '0;
   logic          core_wfi = 1'b0, core_active = 1'b0;
   logic          ack_n_in = 1'b1, deny_in = 1'b0;
   logic          req_n, vret_en;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   rtn_req_channel #(.CNT_W(CW)) i_rtn_req_channel (
      .clk(clk), .rst_n(rst_n),
      .cfg_idle_cycles(cfg_idle), .cfg_entry_settle(cfg_entry),
      .cfg_exit_settle(cfg_exit), .cfg_backoff(cfg_back),
      .core_wfi(core_wfi), .core_active(core_active),
      .ack_n_in(ack_n_in), .deny_in(deny_in),
      .req_n(req_n), .vret_en(vret_en)
   );

   function automatic int exp_idle(int i);          return i + 1;     endfunction
   function automatic int exp_entry(int n);         return n + 4;     endfunction
   function automatic int exp_exit(int m);          return m + 2;     endfunction
   function automatic int exp_retry(int b, int i);  return b + i + 5; endfunction

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // which: 0 = req_n, 1 = vret_en; counts edges until the signal equals val
   task automatic measure(input int which, input logic val, output int n);
      n = 0;
      for (int k = 0; k < 400; k++) begin
         @(posedge clk); #1;
         n++;
         if ((which == 0 ? req_n : vret_en) == val) return;
      end
      n = -1;
   endtask

   task automatic settle_idle();
      core_wfi = 1'b0; core_active = 1'b0; ack_n_in = 1'b1; deny_in = 1'b0;
      repeat (6) @(posedge clk);
      #1;
   endtask

   task automatic hold_no_request(input string req, input logic wfi, input logic act);
      int stayed;
      stayed = 1;
      core_wfi = wfi; core_active = act;
      for (int k = 0; k < 40; k++) begin
         @(posedge clk); #1;
         if (!req_n) stayed = 0;
      end
      check(req, stayed, 1);
      settle_idle();
   endtask

   initial begin
      int n, n2, vseen;
      void'($urandom(32'd1234));
      repeat (3) @(posedge clk);
      #1;
      check("R1 req_n in reset", req_n, 1);
      check("R1 vret_en in reset", vret_en, 0);
      rst_n = 1'b1;
      @(posedge clk); #1;
      check("R1 req_n after reset", req_n, 1);
      check("R1 vret_en after reset", vret_en, 0);
      settle_idle();

      // R3: wait-for-event (no WFI) and an active hint both block requests
      hold_no_request("R3 no WFI", 1'b0, 1'b0);
      hold_no_request("R3 active hint", 1'b1, 1'b1);

      // directed zero counts then random trials
      for (int t = 0; t < 24; t++) begin
         bit use_deny;
         cfg_idle  = (t == 0) ? 8'd0 : 8'($urandom_range(0, 9));
         cfg_entry = (t == 0) ? 8'd0 : 8'($urandom_range(0, 9));
         cfg_exit  = (t == 0) ? 8'd0 : 8'($urandom_range(0, 9));
         cfg_back  = (t == 1) ? 8'd0 : 8'($urandom_range(0, 9));
         use_deny  = (t == 1) ? 1'b1 : ((t == 0) ? 1'b0 : 1'($urandom_range(0, 1)));
         settle_idle();

         core_wfi = 1'b1; core_active = 1'b0;
         measure(0, 1'b0, n);
         check("R2 idle count to request", n, exp_idle(int'(cfg_idle)));

         if (!use_deny) begin
            ack_n_in = 1'b0;
            measure(1, 1'b1, n);
            check("R4 entry settle", n, exp_entry(int'(cfg_entry)));
            check("R4 request held", req_n, 0);
            repeat ($urandom_range(0, 3)) @(posedge clk);
            #0.1;
            core_active = 1'b1;
            measure(1, 1'b0, n);
            check("R5 voltage drop", n, 1);
            measure(0, 1'b1, n2);
            check("R5 exit settle", n + n2, exp_exit(int'(cfg_exit)));
            core_active = 1'b0; core_wfi = 1'b0;
            repeat (2) @(posedge clk);
            #1;
            check("R10 no re-request while ack low", req_n, 1);
            ack_n_in = 1'b1;
         end else begin
            deny_in = 1'b1;
            measure(0, 1'b1, n);
            check("R6 deny release", n, 3);
            repeat (3) @(posedge clk);
            #1;
            check("R10 no re-request while deny high", req_n, 1);
            deny_in = 1'b0;
            measure(0, 1'b0, n);
            check("R7 back-off retry", n, exp_retry(int'(cfg_back), int'(cfg_idle)));
            // R8: acknowledge arrives with activity already set
            ack_n_in = 1'b0; core_active = 1'b1;
            vseen = 0;
            n = 0;
            for (int k = 0; k < 40 && req_n == 1'b0; k++) begin
               @(posedge clk); #1;
               n++;
               if (vret_en) vseen = 1;
            end
            check("R8 abort release", n, 4);
            check("R8 no voltage enable", vseen, 0);
            ack_n_in = 1'b1; core_active = 1'b0; core_wfi = 1'b0;
         end
      end

      settle_idle();
      check("R9 quiet after trials", {req_n, vret_en}, 2'b10);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule